// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store of a 32-bit load/store processor core. It holds 27 physical 32-bit words, and exposes 16 logical registers, R0 to R15, at a time. A 2-bit operating-mode input picks which physical word each logical index reaches. Some registers are common to every mode. Others have private copies for a given mode, so an exception handler can use them without saving the interrupted code's values first.

Two combinational read ports feed the operand path of a data-processing instruction. One synchronous write port takes its result. Two further write strobes serve special cases. One updates R15, the combined program-counter and status word, on every sequential step. The other places a return address in the current mode's R14 on a subroutine call. Reads see a write that lands in the same cycle.

All pins are plain control and data. The block has no streaming interface and applies no back-pressure: it accepts every strobe in every cycle, and its read data is valid in the cycle the index and mode are presented.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high reset clears every physical register to zero, so every index reads zero in every mode afterwards.
- R2: The mode input is encoded 2'b00 user, 2'b01 fast interrupt, 2'b10 interrupt and 2'b11 supervisor. R0 to R7 are a single set shared by all four modes.
- R3: R8 to R12 are shared by user, interrupt and supervisor modes. Fast-interrupt mode has its own separate copies of R8 to R12.
- R4: R13 and R14 have one separate copy per mode, four copies in all. A write in one mode leaves the other modes' copies unchanged.
- R5: R15 is one word shared by all modes. When pc_upd_en is high and no general write targets index 15, pc_upd_data is stored into R15 at the clock edge.
- R6: Both read ports are combinational and independent. A change of mode or index shows on the read data in the same cycle.
- R7: A read of the register being written in the same cycle returns the value being written. This holds for the general port, the link write and the R15 update.
- R8: When link_en is high, link_data is stored into the R14 copy of the current mode.
- R9: When a general write and a dedicated write (the R15 update or the link write) target the same register in the same cycle, the general write's data is stored.
- R10: While wr_en, link_en and pc_upd_en are low, no register changes, whatever wr_idx and wr_data carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Operating mode, encoded as in R2 |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | General write strobe |
| wr_idx | input | 4 | Logical index of the general write |
| wr_data | input | 32 | General write data |
| pc_upd_en | input | 1 | R15 update strobe |
| pc_upd_data | input | 32 | New program-counter/status word |
| link_en | input | 1 | Return-address write strobe, targets the current mode's R14 |
| link_data | input | 32 | Return address |

## Verification
The bench first writes a distinct value into R0 to R14 in each mode, then reads every index back in every mode. A design that banked a register too broadly or too narrowly would show the value from another mode. Missing fast-interrupt copies of R8 to R12 is the most likely way to get this wrong. The bench switches modes on consecutive cycles while reading R13 and R14, which exposes a mode path that was registered instead of combinational. It also reads each index in the same cycle it is written by each of the three write paths, so a missing bypass returns the old value. Collisions of the general write with the R15 update and with the link write would store the dedicated value if the priority were inverted. A long random phase then compares both ports against a behavioural model on every clock.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef enum logic [1:0] {
    MODE_USER = 2'b00,
    MODE_FAST = 2'b01,
    MODE_IRQ  = 2'b10,
    MODE_SUPV = 2'b11
  } op_mode_e;

  localparam int unsigned NUM_LOGICAL = 16;
  localparam int unsigned IDX_W       = $clog2(NUM_LOGICAL);
  // user/shared set 0..15, fast copies of R8..R14, then irq and supervisor R13/R14
  localparam int unsigned FAST_LO     = 8;
  localparam int unsigned FAST_CNT    = 7;
  localparam int unsigned SWAP_LO     = 13;
  localparam int unsigned SWAP_CNT    = 2;
  localparam int unsigned FAST_BASE   = NUM_LOGICAL;
  localparam int unsigned IRQ_BASE    = FAST_BASE + FAST_CNT;
  localparam int unsigned SUPV_BASE   = IRQ_BASE + SWAP_CNT;
  localparam int unsigned NUM_PHYS    = SUPV_BASE + SWAP_CNT;
  localparam int unsigned PHYS_W      = $clog2(NUM_PHYS);
  localparam int unsigned PC_IDX      = NUM_LOGICAL - 1;
  localparam int unsigned LINK_IDX    = NUM_LOGICAL - 2;
endpackage

// File: rtl/regbank_map.sv
module regbank_map
  import regbank_pkg::*;
(
  input  op_mode_e          mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] phys
);
  logic in_fast, in_swap;

  assign in_fast = (idx >= IDX_W'(FAST_LO)) && (idx < IDX_W'(FAST_LO + FAST_CNT));
  assign in_swap = (idx >= IDX_W'(SWAP_LO)) && (idx < IDX_W'(SWAP_LO + SWAP_CNT));

  always_comb begin
    phys = PHYS_W'(idx);
    unique case (mode)
      MODE_FAST: if (in_fast) phys = PHYS_W'(FAST_BASE) + PHYS_W'(idx) - PHYS_W'(FAST_LO);
      MODE_IRQ:  if (in_swap) phys = PHYS_W'(IRQ_BASE) + PHYS_W'(idx) - PHYS_W'(SWAP_LO);
      MODE_SUPV: if (in_swap) phys = PHYS_W'(SUPV_BASE) + PHYS_W'(idx) - PHYS_W'(SWAP_LO);
      default:   phys = PHYS_W'(idx);
    endcase
  end

  always_comb begin
    assert_low_shared_R2: assert (idx >= IDX_W'(FAST_LO) || phys == PHYS_W'(idx));
    assert_pc_common_R5:  assert (idx != IDX_W'(PC_IDX) || phys == PHYS_W'(PC_IDX));
    assert_in_range_R4:   assert (phys < PHYS_W'(NUM_PHYS));
  end
endmodule

// File: rtl/regbank_store.sv
module regbank_store
  import regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PHYS_W-1:0] wr_phys,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              link_en,
  input  logic [PHYS_W-1:0] link_phys,
  input  logic [DATA_W-1:0] link_data,
  input  logic              pc_en,
  input  logic [DATA_W-1:0] pc_data,
  output logic [DATA_W-1:0] q   [NUM_PHYS],
  output logic [DATA_W-1:0] nxt [NUM_PHYS],
  output logic [NUM_PHYS-1:0] hit
);
  for (genvar i = 0; i < int'(NUM_PHYS); i++) begin : g_reg
    logic sel_gen, sel_link, sel_pc;
    assign sel_gen  = wr_en && (wr_phys == PHYS_W'(i));
    assign sel_link = link_en && (link_phys == PHYS_W'(i));
    assign sel_pc   = pc_en && (i == int'(PC_IDX));
    assign hit[i]   = !rst && (sel_gen || sel_link || sel_pc);

    // general write outranks the dedicated paths
    always_comb begin
      if (sel_gen)       nxt[i] = wr_data;
      else if (sel_link) nxt[i] = link_data;
      else               nxt[i] = pc_data;
    end

    always_ff @(posedge clk) begin
      if (rst)         q[i] <= '0;
      else if (hit[i]) q[i] <= nxt[i];
    end
  end

  // checker state for the link write
  logic              chk_link;
  logic [PHYS_W-1:0] chk_link_phys;
  logic [DATA_W-1:0] chk_link_data;
  logic [DATA_W-1:0] q_at_link;
  logic [DATA_W-1:0] q_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_link      <= 1'b0;
      chk_link_phys <= '0;
      chk_link_data <= '0;
    end else begin
      chk_link      <= link_en && !(wr_en && wr_phys == link_phys);
      chk_link_phys <= link_phys;
      chk_link_data <= link_data;
    end
  end

  assign q_at_link = q[chk_link_phys];
  assign q_pc      = q[PC_IDX];

  assert_link_stored_R8: assert property (@(posedge clk) disable iff (rst)
    chk_link |-> q_at_link == chk_link_data);

  assert_pc_update_R5: assert property (@(posedge clk) disable iff (rst)
    pc_en && !(wr_en && wr_phys == PHYS_W'(PC_IDX)) |=> q_pc == $past(pc_data));

  assert_general_wins_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_phys == PHYS_W'(PC_IDX) |=> q_pc == $past(wr_data));
endmodule

// File: rtl/regbank_read.sv
module regbank_read
  import regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [PHYS_W-1:0]   phys,
  input  logic [DATA_W-1:0]   q   [NUM_PHYS],
  input  logic [DATA_W-1:0]   nxt [NUM_PHYS],
  input  logic [NUM_PHYS-1:0] hit,
  output logic [DATA_W-1:0]   data
);
  assign data = hit[phys] ? nxt[phys] : q[phys];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pc_upd_en,
  input  logic [DATA_W-1:0] pc_upd_data,
  input  logic              link_en,
  input  logic [DATA_W-1:0] link_data
);
  localparam int unsigned NUM_RD  = 2;
  localparam int unsigned NUM_MAP = NUM_RD + 2;

  op_mode_e          cur_mode;
  logic [IDX_W-1:0]  map_idx  [NUM_MAP];
  logic [PHYS_W-1:0] map_phys [NUM_MAP];
  logic [DATA_W-1:0] rd_data  [NUM_RD];
  logic [DATA_W-1:0] q   [NUM_PHYS];
  logic [DATA_W-1:0] nxt [NUM_PHYS];
  logic [NUM_PHYS-1:0] hit;

  assign cur_mode   = op_mode_e'(mode);
  assign map_idx[0] = rd_a_idx;
  assign map_idx[1] = rd_b_idx;
  assign map_idx[2] = wr_idx;
  assign map_idx[3] = IDX_W'(LINK_IDX);

  for (genvar m = 0; m < int'(NUM_MAP); m++) begin : g_map
    regbank_map u_map (
      .mode (cur_mode),
      .idx  (map_idx[m]),
      .phys (map_phys[m])
    );
  end

  regbank_store #(.DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_phys   (map_phys[2]),
    .wr_data   (wr_data),
    .link_en   (link_en),
    .link_phys (map_phys[3]),
    .link_data (link_data),
    .pc_en     (pc_upd_en),
    .pc_data   (pc_upd_data),
    .q         (q),
    .nxt       (nxt),
    .hit       (hit)
  );

  for (genvar r = 0; r < int'(NUM_RD); r++) begin : g_rd
    regbank_read #(.DATA_W(DATA_W)) u_rd (
      .phys (map_phys[r]),
      .q    (q),
      .nxt  (nxt),
      .hit  (hit),
      .data (rd_data[r])
    );
  end

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && !wr_en && !link_en && !pc_upd_en |-> rd_a_data == '0 && rd_b_data == '0);

  assert_bypass_a_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en && rd_a_idx == wr_idx |-> rd_a_data == wr_data);

  assert_bypass_b_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en && rd_b_idx == wr_idx |-> rd_b_data == wr_data);
endmodule

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  mode;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, pc_upd_data, link_data;
  logic        wr_en, pc_upd_en, link_en;

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          done   = 1'b0;

  // behavioural model: 4 banks x 16 slots, shared slots live in bank 0
  logic [31:0] mdl [64];

  always #4 clk = ~clk;

  banked_regfile dut_i (
    .clk(clk), .rst(rst), .mode(mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_upd_en(pc_upd_en), .pc_upd_data(pc_upd_data),
    .link_en(link_en), .link_data(link_data)
  );

  function automatic int key_of(logic [1:0] m, logic [3:0] i);
    int bank;
    if (i == 4'd15 || i < 4'd8) bank = 0;
    else if (i < 4'd13)         bank = (m == 2'b01) ? 1 : 0;
    else                        bank = int'(m);
    return bank * 16 + int'(i);
  endfunction

  function automatic string tag_of(logic [3:0] i);
    if (i < 4'd8)  return "R2";
    if (i < 4'd13) return "R3";
    if (i < 4'd15) return "R4";
    return "R5";
  endfunction

  function automatic logic [31:0] expect_rd(logic [3:0] i);
    int k = key_of(mode, i);
    if (wr_en && key_of(mode, wr_idx) == k) return wr_data;
    if (link_en && key_of(mode, 4'd14) == k) return link_data;
    if (pc_upd_en && i == 4'd15) return pc_upd_data;
    return mdl[k];
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; link_en = 0; pc_upd_en = 0;
    wr_idx = 4'($urandom); wr_data = $urandom;
    link_data = $urandom; pc_upd_data = $urandom;
  endtask

  // one clock: compare both ports, commit model, advance to next negedge
  task automatic step(string req);
    logic [31:0] ea, eb;
    #1;
    ea = expect_rd(rd_a_idx);
    eb = expect_rd(rd_b_idx);
    chk({req, "/", tag_of(rd_a_idx)}, $sformatf("port A mode=%0d idx=%0d", mode, rd_a_idx), rd_a_data, ea);
    chk({req, "/", tag_of(rd_b_idx)}, $sformatf("port B mode=%0d idx=%0d", mode, rd_b_idx), rd_b_data, eb);
    if (pc_upd_en) mdl[key_of(mode, 4'd15)] = pc_upd_data;
    if (link_en)   mdl[key_of(mode, 4'd14)] = link_data;
    if (wr_en)     mdl[key_of(mode, wr_idx)] = wr_data;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; mode = 0; rd_a_idx = 0; rd_b_idx = 0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    for (int k = 0; k < 64; k++) mdl[k] = '0;

    // R1: all zero after reset, every mode, every index
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 8; i++) begin
        mode = 2'(m); rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i);
        step("R1 reset");
      end

    // R2 R3 R4: distinct values per mode into R0..R14
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 15; i++) begin
        mode = 2'(m); wr_en = 1; wr_idx = 4'(i);
        wr_data = 32'hA500_0000 | (m << 8) | i;
        rd_a_idx = 4'(i); rd_b_idx = 4'((i + 3) % 16);
        step("R2 banking write");
      end
    idle();
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 8; i++) begin
        mode = 2'(m); rd_a_idx = 4'(i); rd_b_idx = 4'(i + 8);
        step("R3 R4 banking readback");
      end

    // R6: mode change shows on read data in the same cycle
    for (int n = 0; n < 8; n++) begin
      mode = 2'(n % 4); rd_a_idx = 4'd13; rd_b_idx = 4'd14;
      step("R6 mode switch");
    end

    // R5: dedicated R15 update, seen in other modes
    mode = 2'b11; pc_upd_en = 1; pc_upd_data = 32'h0000_8004;
    rd_a_idx = 4'd15; rd_b_idx = 4'd0;
    step("R5 R7 pc update bypass");
    idle(); mode = 2'b01; rd_a_idx = 4'd15;
    step("R5 pc shared");

    // R9: general write to R15 beats the dedicated update
    mode = 2'b10; wr_en = 1; wr_idx = 4'd15; wr_data = 32'h1234_5678;
    pc_upd_en = 1; pc_upd_data = 32'hDEAD_0000;
    rd_a_idx = 4'd15; rd_b_idx = 4'd15;
    step("R9 pc collision");
    idle(); mode = 2'b00; rd_a_idx = 4'd15;
    step("R9 pc collision stored");

    // R8: link write to the current mode's R14
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m); link_en = 1; link_data = 32'hC0DE_0000 | m;
      rd_a_idx = 4'd14; rd_b_idx = 4'd13;
      step("R8 R7 link bypass");
      idle();
    end
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m); rd_a_idx = 4'd14; rd_b_idx = 4'd14;
      step("R8 link per mode");
    end

    // R9: general write to R14 beats the link write
    mode = 2'b10; wr_en = 1; wr_idx = 4'd14; wr_data = 32'h5555_AAAA;
    link_en = 1; link_data = 32'h0BAD_0BAD; rd_a_idx = 4'd14;
    step("R9 link collision");
    idle(); rd_a_idx = 4'd14;
    step("R9 link collision stored");

    // R10: strobes low, data ignored
    for (int n = 0; n < 16; n++) begin
      idle(); mode = 2'($urandom); rd_a_idx = wr_idx; rd_b_idx = 4'($urandom);
      step("R10 idle");
    end

    // random traffic, R7 bypass included
    for (int n = 0; n < 3000; n++) begin
      mode = 2'($urandom); rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
      wr_en = 1'($urandom); wr_idx = 4'($urandom); wr_data = $urandom;
      if (n % 5 == 0) rd_b_idx = wr_idx;
      link_en = ($urandom % 6) == 0; link_data = $urandom;
      pc_upd_en = 1'($urandom); pc_upd_data = $urandom;
      step("R7 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule